// File: doc/BRIEF.md
# DMA Repeat-Offset Transfer Channel

This block is one DMA channel that copies data element by element from a source region to a destination region. It moves one element for each transfer request it accepts. Each move is a single-beat read followed by a single-beat write, and both use a valid/ready memory port. After every element the destination advances by the element size. The source instead advances by a programmable offset, so the channel can walk down a column of a matrix that is stored row by row.

The source is organised in repeat blocks of a programmed length. When a block finishes, the source address snaps back to the address at which the block started and the channel stops itself. It then raises a repeat-end interrupt. Software can now point the source at the next column by rewriting the source address and set the enable bit again. The channel carries on from its held state, and the destination keeps running on contiguously. Repeated over all columns, this transposes a matrix (a rows-to-columns conversion). A separate interrupt marks the point where the total element count is used up.

Top module: `dma_repeat_offset_chan`

## Requirements
- R1: CTRL bits [2:1] pick the element size: 0 = byte, 1 = word, 2 = longword (3 is not used). `memSize` carries this code. After each completed element the destination address grows by 1, 2 or 4 respectively.
- R2: Inside a repeat block, each completed element adds the offset register to the current source address, modulo 2^ADDR_W.
- R3: The element that uses up the repeat size reloads the source address with the block start address and reloads the repeat counter from its programmed value. It also sets the repeat-end flag and clears the enable bit.
- R4: Transfer requests that arrive while the enable bit is 0 start no memory access. This covers a suspended channel as well as a finished one.
- R5: Writing the enable bit to 1 after a suspension resumes from the held count, repeat counter and destination address. If the source address was rewritten while the channel was suspended, the next read goes to the new address.
- R6: The element that brings the total count to zero sets the end flag and clears the enable bit. When it also ends a repeat block, only the end flag is set.
- R7: Each element is one read of the source followed in the next cycle by a write of the same data to the destination. Valid, address and direction hold steady until ready is seen.
- R8: Both flags are sticky. Writing CLR bit 0 clears the repeat flag and writing CLR bit 1 clears the end flag. `irqRepeatEnd` is the repeat flag gated by CTRL bit 3, and `irqXferEnd` is the end flag gated by CTRL bit 4.
- R9: After reset `memValid`, `irqRepeatEnd` and `irqXferEnd` are low, and the enable bit is 0.
- R10: A transfer starts only when the channel is idle and enabled and `xferReq` is high. A request held high during an element has no further effect.
- R11: The register index `regAddr` selects a register: 0 = source address (writes both the block start and the current source), 1 = destination, 2 = offset, 3 = repeat size (writes both the programmed value and the counter), 4 = total count, 5 = CTRL (bit 0 enable), 6 = CLR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write value |
| xferReq | input | 1 | Transfer request |
| memValid | output | 1 | Memory beat valid |
| memWrite | output | 1 | 1 = write beat, 0 = read beat |
| memSize | output | 2 | Element size code |
| memAddr | output | ADDR_W | Beat address |
| memWrData | output | DATA_W | Write data |
| memRdData | input | DATA_W | Read data, taken when a read beat sees ready |
| memReady | input | 1 | Memory accepts the current beat |
| irqRepeatEnd | output | 1 | Masked repeat-end interrupt |
| irqXferEnd | output | 1 | Masked transfer-end interrupt |

## Verification
The main test is a 4-by-4 longword transposition with a row-stride offset. Software advances the column between blocks, which separates the reload-to-block-start behaviour from plain offset addition and shows whether a rewritten source is used on resume. A byte-sized run with a short block and no source rewrite shows that the destination keeps advancing contiguously across a suspension. It also exercises the masks and the clear register. A request held high across a transfer distinguishes edge-accepted work from level-repeated work. A word-sized run with a negative offset checks address wrap. In the final element of the transposition a repeat end and the count end fall together, which exposes the priority between the two flags.

// File: rtl/dma_ro_pkg.sv
package dma_ro_pkg;
  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_OFF  = 3'd2;
  localparam logic [2:0] REG_REP  = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_CTRL = 3'd5;
  localparam logic [2:0] REG_CLR  = 3'd6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } accSize_e;

  typedef struct packed {
    logic captureRead;
    logic commitXfer;
  } dpStrobe_t;
endpackage

// File: rtl/dma_ro_datapath.sv
module dma_ro_datapath
  import dma_ro_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        accSize,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] srcCur,
  output logic [ADDR_W-1:0] dstCur,
  output logic [DATA_W-1:0] dataLatch,
  output logic              lastXfer,
  output logic              lastInBlock
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] srcStart;
  logic [ADDR_W-1:0] offset;
  logic [CNT_W-1:0]  repSize;
  logic [CNT_W-1:0]  repLeft;
  logic [CNT_W-1:0]  cntLeft;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    case (accSize)
      SZ_BYTE: stride = ADDR_W'(1);
      SZ_WORD: stride = ADDR_W'(2);
      default: stride = ADDR_W'(4);
    endcase
  end

  assign lastXfer    = (cntLeft <= CNT_ONE);
  assign lastInBlock = (repLeft <= CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcStart  <= '0;
      srcCur    <= '0;
      dstCur    <= '0;
      offset    <= '0;
      repSize   <= '0;
      repLeft   <= '0;
      cntLeft   <= '0;
      dataLatch <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          REG_SRC: begin
            srcStart <= regWrData[ADDR_W-1:0];
            srcCur   <= regWrData[ADDR_W-1:0];
          end
          REG_DST: dstCur <= regWrData[ADDR_W-1:0];
          REG_OFF: offset <= regWrData[ADDR_W-1:0];
          REG_REP: begin
            repSize <= regWrData[CNT_W-1:0];
            repLeft <= regWrData[CNT_W-1:0];
          end
          REG_CNT: cntLeft <= regWrData[CNT_W-1:0];
          default: ;
        endcase
      end
      if (strobe.captureRead) dataLatch <= memRdData;
      if (strobe.commitXfer) begin
        cntLeft <= cntLeft - CNT_ONE;
        dstCur  <= dstCur + stride;
        if (lastInBlock) begin
          srcCur  <= srcStart;
          repLeft <= repSize;
        end else begin
          srcCur  <= srcCur + offset;
          repLeft <= repLeft - CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/dma_ro_ctrl.sv
module dma_ro_ctrl
  import dma_ro_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             xferReq,
  input  logic             memReady,
  input  logic             lastXfer,
  input  logic             lastInBlock,
  output logic             memValid,
  output logic             memWrite,
  output dpStrobe_t        strobe,
  output logic [1:0]       accSize,
  output logic             chanEnable,
  output logic             flagRep,
  output logic             flagEnd,
  output logic             irqRepeatEnd,
  output logic             irqXferEnd
);
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

  phase_e phase;
  logic   maskRep;
  logic   maskEnd;

  assign memValid           = (phase != PH_IDLE);
  assign memWrite           = (phase == PH_WRITE);
  assign strobe.captureRead = (phase == PH_READ) && memReady;
  assign strobe.commitXfer  = (phase == PH_WRITE) && memReady;
  assign irqRepeatEnd       = flagRep & maskRep;
  assign irqXferEnd         = flagEnd & maskEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  if (chanEnable && xferReq) phase <= PH_READ;
        PH_READ:  if (memReady) phase <= PH_WRITE;
        PH_WRITE: if (memReady) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnable <= 1'b0;
      accSize    <= SZ_BYTE;
      maskRep    <= 1'b0;
      maskEnd    <= 1'b0;
      flagRep    <= 1'b0;
      flagEnd    <= 1'b0;
    end else begin
      if (regWrEn && regAddr == REG_CTRL) begin
        chanEnable <= regWrData[0];
        accSize    <= regWrData[2:1];
        maskRep    <= regWrData[3];
        maskEnd    <= regWrData[4];
      end
      if (regWrEn && regAddr == REG_CLR) begin
        if (regWrData[0]) flagRep <= 1'b0;
        if (regWrData[1]) flagEnd <= 1'b0;
      end
      if (strobe.commitXfer) begin
        if (lastXfer) begin
          flagEnd    <= 1'b1;
          chanEnable <= 1'b0;
        end else if (lastInBlock) begin
          flagRep    <= 1'b1;
          chanEnable <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_repeat_offset_chan.sv
module dma_repeat_offset_chan
  import dma_ro_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic              xferReq,
  output logic              memValid,
  output logic              memWrite,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memReady,
  output logic              irqRepeatEnd,
  output logic              irqXferEnd
);
  localparam int REG_W = 32;

  dpStrobe_t         strobe;
  logic [1:0]        accSize;
  logic [ADDR_W-1:0] srcCur;
  logic [ADDR_W-1:0] dstCur;
  logic              lastXfer;
  logic              lastInBlock;
  logic              chanEnable;
  logic              flagRep;
  logic              flagEnd;

  dma_ro_ctrl #(.REG_W(REG_W)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .xferReq(xferReq), .memReady(memReady),
    .lastXfer(lastXfer), .lastInBlock(lastInBlock), .memValid(memValid),
    .memWrite(memWrite), .strobe(strobe), .accSize(accSize),
    .chanEnable(chanEnable), .flagRep(flagRep), .flagEnd(flagEnd),
    .irqRepeatEnd(irqRepeatEnd), .irqXferEnd(irqXferEnd)
  );

  dma_ro_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .accSize(accSize),
    .memRdData(memRdData), .srcCur(srcCur), .dstCur(dstCur),
    .dataLatch(memWrData), .lastXfer(lastXfer), .lastInBlock(lastInBlock)
  );

  assign memAddr = memWrite ? dstCur : srcCur;
  assign memSize = accSize;
endmodule

// File: rtl/dma_ro_checker.sv
module dma_ro_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memValid,
  input logic              memWrite,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memRdData,
  input logic [DATA_W-1:0] memWrData,
  input logic              chanEnable,
  input logic              flagRep,
  input logic              flagEnd
);
  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && memReady) |=> (memValid && memWrite));

  assert_write_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && memReady) |=> (memWrData == $past(memRdData)));

  assert_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEnable && !memValid) |=> !memValid);

  assert_suspend_clears_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagRep) |-> !chanEnable);

  assert_end_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagEnd) |-> (!$rose(flagRep) && !chanEnable));
endmodule

bind dma_repeat_offset_chan dma_ro_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memWrite(memWrite),
  .memReady(memReady), .memAddr(memAddr), .memRdData(memRdData),
  .memWrData(memWrData), .chanEnable(chanEnable), .flagRep(flagRep),
  .flagEnd(flagEnd)
);

// File: tb/dma_repeat_offset_chan_test.sv
module dma_repeat_offset_chan_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        xferReq = 1'b0;
  logic        memValid, memWrite;
  logic [1:0]  memSize;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;
  logic        memReady = 1'b0;
  logic        irqRepeatEnd, irqXferEnd;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  // reference model state
  int          mPhase = 0;
  logic [31:0] mSrcStart = 0, mSrc = 0, mDst = 0, mOff = 0, mLatch = 0;
  int          mRepSize = 0, mRepLeft = 0, mCnt = 0, mSize = 0;
  bit          mEn = 0, mMaskR = 0, mMaskE = 0, mFlagR = 0, mFlagE = 0;

  // values in effect at the coming edge
  bit          pHave = 0;
  bit          pValid, pWrite, pReady, pReq, pRegWr;
  logic [31:0] pAddr, pWdata, pRdata, pRegData;
  logic [2:0]  pRegAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_repeat_offset_chan uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .xferReq(xferReq), .memValid(memValid),
    .memWrite(memWrite), .memSize(memSize), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .memReady(memReady),
    .irqRepeatEnd(irqRepeatEnd), .irqXferEnd(irqXferEnd)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] strideOf(int sz);
    return (sz == 0) ? 32'd1 : (sz == 1) ? 32'd2 : 32'd4;
  endfunction

  task automatic modelStep();
    if (pValid && pReady) begin
      if (!pWrite) begin
        check("R2/R3/R5/R11 read address", pAddr, mSrc);
        mLatch = pRdata;
        mPhase = 2;
      end else begin
        bit endNow = (mCnt <= 1);
        bit blkNow = (mRepLeft <= 1);
        check("R1 write address", pAddr, mDst);
        check("R7 write data", pWdata, mLatch);
        mCnt--;
        mDst += strideOf(mSize);
        if (blkNow) begin
          mSrc = mSrcStart;
          mRepLeft = mRepSize;
        end else begin
          mSrc += mOff;
          mRepLeft--;
        end
        if (endNow) begin
          mFlagE = 1; mEn = 0;
        end else if (blkNow) begin
          mFlagR = 1; mEn = 0;
        end
        mPhase = 0;
      end
    end else if (mPhase == 0 && mEn && pReq) begin
      mPhase = 1;
    end
    if (pRegWr) begin
      case (pRegAddr)
        3'd0: begin mSrcStart = pRegData; mSrc = pRegData; end
        3'd1: mDst = pRegData;
        3'd2: mOff = pRegData;
        3'd3: begin mRepSize = int'(pRegData[15:0]); mRepLeft = mRepSize; end
        3'd4: mCnt = int'(pRegData[15:0]);
        3'd5: begin
          mEn = pRegData[0]; mSize = int'(pRegData[2:1]);
          mMaskR = pRegData[3]; mMaskE = pRegData[4];
        end
        3'd6: begin
          if (pRegData[0]) mFlagR = 0;
          if (pRegData[1]) mFlagE = 0;
        end
        default: ;
      endcase
    end
    check("R4/R7/R10 memValid", 32'(memValid), 32'(mPhase != 0));
    if (memValid) begin
      check("R7 direction", 32'(memWrite), 32'(mPhase == 2));
      check("R1 memSize", 32'(memSize), 32'(mSize));
    end
    check("R3/R8 irqRepeatEnd", 32'(irqRepeatEnd), 32'(mFlagR && mMaskR));
    check("R6/R8 irqXferEnd", 32'(irqXferEnd), 32'(mFlagE && mMaskE));
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      pHave = 0;
      memReady = 1'b0;
    end else begin
      if (pHave) modelStep();
      cyc++;
      memReady  = (cyc % 3) != 1;
      memRdData = {memAddr[15:0] ^ 16'h5A5A, memAddr[15:0] + 16'(cyc)};
      pValid = memValid; pWrite = memWrite; pReady = memReady;
      pAddr = memAddr; pWdata = memWrData; pRdata = memRdData;
      pReq = xferReq; pRegWr = regWrEn; pRegAddr = regAddr; pRegData = regWrData;
      pHave = 1;
    end
  end

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic oneXfer();
    xferReq = 1'b1;
    @(posedge clk); #1;
    xferReq = 1'b0;
    while (memValid) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 memValid after reset", 32'(memValid), 32'd0);
    check("R9 irqRepeatEnd after reset", 32'(irqRepeatEnd), 32'd0);
    check("R9 irqXferEnd after reset", 32'(irqXferEnd), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    oneXfer();  // not enabled: must be ignored (R4)
    check("R4 request before enable", 32'(memValid), 32'd0);

    // 4x4 longword transposition
    regWrite(3'd0, 32'h0000_1000);
    regWrite(3'd1, 32'h0000_2000);
    regWrite(3'd2, 32'd16);
    regWrite(3'd3, 32'd4);
    regWrite(3'd4, 32'd16);
    regWrite(3'd5, 32'h1D);
    for (int col = 0; col < 4; col++) begin
      for (int row = 0; row < 4; row++) oneXfer();
      if (col < 3) begin
        check("R3 repeat-end raised", 32'(irqRepeatEnd), 32'd1);
        oneXfer();
        check("R4 request while suspended", 32'(memValid), 32'd0);
        regWrite(3'd0, 32'h0000_1000 + 32'(4 * (col + 1)));
        regWrite(3'd6, 32'h1);
        check("R8 repeat flag cleared", 32'(irqRepeatEnd), 32'd0);
        regWrite(3'd5, 32'h1D);  // R5 resume
      end
    end
    check("R6 end raised", 32'(irqXferEnd), 32'd1);
    check("R6 end has priority over repeat-end", 32'(irqRepeatEnd), 32'd0);
    oneXfer();
    check("R4 request after end", 32'(memValid), 32'd0);
    regWrite(3'd6, 32'h2);

    // byte run, masks off, resume without rewriting source
    regWrite(3'd0, 32'h0000_0400);
    regWrite(3'd1, 32'h0000_3000);
    regWrite(3'd2, 32'd3);
    regWrite(3'd3, 32'd3);
    regWrite(3'd4, 32'd5);
    regWrite(3'd5, 32'h01);
    for (int i = 0; i < 3; i++) oneXfer();
    check("R8 masked repeat-end", 32'(irqRepeatEnd), 32'd0);
    regWrite(3'd5, 32'h08);
    check("R8 sticky flag shown once unmasked", 32'(irqRepeatEnd), 32'd1);
    regWrite(3'd6, 32'h1);
    check("R8 clear via CLR bit 0", 32'(irqRepeatEnd), 32'd0);
    regWrite(3'd5, 32'h19);
    xferReq = 1'b1;  // R10: held request
    repeat (12) begin @(posedge clk); #1; end
    xferReq = 1'b0;
    while (memValid) begin @(posedge clk); #1; end
    check("R6 byte run end", 32'(irqXferEnd), 32'd1);
    regWrite(3'd6, 32'h3);

    // word run with negative offset
    regWrite(3'd0, 32'h0000_0010);
    regWrite(3'd1, 32'hFFFF_FFFC);
    regWrite(3'd2, 32'hFFFF_FFF0);
    regWrite(3'd3, 32'd2);
    regWrite(3'd4, 32'd4);
    regWrite(3'd5, 32'h1B);
    for (int i = 0; i < 2; i++) oneXfer();
    check("R3 word repeat-end", 32'(irqRepeatEnd), 32'd1);
    regWrite(3'd6, 32'h1);
    regWrite(3'd5, 32'h1B);
    for (int i = 0; i < 2; i++) oneXfer();
    check("R6 word run end", 32'(irqXferEnd), 32'd1);
    repeat (3) begin @(posedge clk); #1; end
    summary();
    $finish;
  end
endmodule